// File: doc/BRIEF.md
# System Management Memory Access Decoder

This block sits on the processor memory request path and gives each request one of two destinations. A request can go to DRAM, including the hidden system-management areas, or it can be forwarded to the PCI bus. The block also gives each request a cacheability attribute.

Two hidden areas are decoded:
- A fixed low window at 0x000A0000–0x000BFFFF, which is non-cacheable.
- A segment taken from the very top of installed DRAM, which is write-back cacheable.

Access to either area is granted while the processor is in system-management mode, or while a software-controlled open bit is set.

An access to a hidden area without a grant is not faulted. It is sent to PCI instead, and a sticky violation flag is raised. Software clears the flag by writing a one. A data-alias bit lets data accesses to the low window reach the normal aliased (PCI) space while code fetches still hit the hidden DRAM.

The response is registered. Every request strobe produces a response strobe exactly one clock later, with the route and attribute held until the next request.

Top module: `smm_access_decoder`

## Requirements
- R1: The low window 0x000A0000–0x000BFFFF is hidden only when the 3-bit base field equals 3'b010 and the global enable is 1. Otherwise a request there goes to PCI (rspToDram=0), non-cacheable, and sets no status.
- R2: A granted request to the active low window goes to DRAM (rspToDram=1) with rspCacheable=0.
- R3: With the alias bit set, a data request (reqIsCode=0) to the active low window goes to PCI, non-cacheable, whatever the grant, and sets no status. A code fetch there still follows R2 and R7.
- R4: The size field maps 2'b00=128 KB, 2'b01=256 KB, 2'b10=512 KB and 2'b11=1 MB. While the global enable is 1, the top segment spans [topOfMem − size, topOfMem − 1].
- R5: A granted request to the top segment goes to DRAM with rspCacheable=1.
- R6: A request is granted when smmActive=1 or the open bit is 1.
- R7: An ungranted request to an active hidden area goes to PCI, non-cacheable, and sets violationSticky.
- R8: violationSticky stays 1 until statusClear is pulsed. A clear alone drops it after that edge. A clear in the same cycle as a new violation leaves it 1.
- R9: A request outside the hidden areas goes to DRAM, cacheable, when below topOfMem. At or above topOfMem it goes to PCI, non-cacheable.
- R10: rspValid is 1 exactly in the cycle after reqValid is 1. rspToDram and rspCacheable change only on a request and hold otherwise.
- R11: While rstN is low, rspValid, rspToDram, rspCacheable and violationSticky are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Request address |
| reqIsCode | input | 1 | 1 = code fetch, 0 = data access |
| smmActive | input | 1 | Processor is in system-management mode |
| topOfMem | input | ADDR_W | First address above installed DRAM |
| cfgBaseSeg | input | 3 | Low-window select; 3'b010 enables it |
| cfgGlobalEn | input | 1 | Global enable of hidden areas |
| cfgDataOpen | input | 1 | Open bit: grants access outside SMM |
| cfgDataAlias | input | 1 | Send data accesses in the low window to aliased space |
| cfgSegSize | input | 2 | Top segment size code |
| statusClear | input | 1 | Write-one-to-clear of the violation flag |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspToDram | output | 1 | 1 = DRAM, 0 = PCI |
| rspCacheable | output | 1 | 1 = write-back cacheable |
| violationSticky | output | 1 | Sticky blocked-access flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 128 KB segment unit and the fixed low window. topOfMem is set to 0x08000000. With these values, every one of the four size codes puts its segment base at a distinct, easily computed address. The bench can then probe both sides of every top-segment boundary. It can also probe both ends of the low window together with every combination of grant, alias and code/data.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;

  typedef enum logic [1:0] {
    REGION_MAIN   = 2'd0,
    REGION_LEGACY = 2'd1,
    REGION_TOP    = 2'd2,
    REGION_HIGH   = 2'd3
  } region_e;

  typedef struct packed {
    logic load;
    logic toDram;
    logic cacheable;
    logic flagViol;
    logic clearViol;
  } dpStrobe_t;

  localparam logic [2:0] LEGACY_SEG_CODE = 3'b010;

endpackage

// File: rtl/smm_dec_datapath.sv
module smm_dec_datapath
  import smm_dec_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned SEG_UNIT_SHIFT = 17,
  parameter logic [31:0] LEG_LO         = 32'h000A_0000,
  parameter logic [31:0] LEG_HI         = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] topOfMem,
  input  logic [1:0]        cfgSegSize,
  input  dpStrobe_t         strobe,
  output region_e           region,
  output logic              rspValid,
  output logic              rspToDram,
  output logic              rspCacheable,
  output logic              violationSticky
);

  localparam int unsigned SIZE_CODES = 4;
  localparam logic [ADDR_W-1:0] legLo = ADDR_W'(LEG_LO);
  localparam logic [ADDR_W-1:0] legHi = ADDR_W'(LEG_HI);

  logic [ADDR_W-1:0] sizeTable [SIZE_CODES];

  for (genvar g = 0; g < SIZE_CODES; g++) begin : g_size
    assign sizeTable[g] = ADDR_W'(1) << (SEG_UNIT_SHIFT + g);
  end

  logic [ADDR_W-1:0] segSize;
  logic [ADDR_W-1:0] topBase;
  logic              inLegacy;
  logic              inTop;
  logic              belowTom;

  always_comb begin
    segSize  = sizeTable[cfgSegSize];
    topBase  = topOfMem - segSize;
    inLegacy = (reqAddr >= legLo) && (reqAddr <= legHi);
    belowTom = reqAddr < topOfMem;
    inTop    = (reqAddr >= topBase) && belowTom;
    if (inLegacy)      region = REGION_LEGACY;
    else if (inTop)    region = REGION_TOP;
    else if (belowTom) region = REGION_MAIN;
    else               region = REGION_HIGH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid        <= 1'b0;
      rspToDram       <= 1'b0;
      rspCacheable    <= 1'b0;
      violationSticky <= 1'b0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspToDram    <= strobe.toDram;
        rspCacheable <= strobe.cacheable;
      end
      violationSticky <= (violationSticky & ~strobe.clearViol) | strobe.flagViol;
    end
  end

endmodule

// File: rtl/smm_dec_control.sv
module smm_dec_control
  import smm_dec_pkg::*;
(
  input  region_e    region,
  input  logic       reqValid,
  input  logic       reqIsCode,
  input  logic       smmActive,
  input  logic [2:0] cfgBaseSeg,
  input  logic       cfgGlobalEn,
  input  logic       cfgDataOpen,
  input  logic       cfgDataAlias,
  input  logic       statusClear,
  output dpStrobe_t  strobe
);

  logic legacyOn;
  logic granted;
  logic toDram;
  logic cacheable;
  logic blocked;

  always_comb begin
    legacyOn  = cfgGlobalEn && (cfgBaseSeg == LEGACY_SEG_CODE);
    granted   = smmActive || cfgDataOpen;
    toDram    = 1'b0;
    cacheable = 1'b0;
    blocked   = 1'b0;
    unique case (region)
      REGION_LEGACY: begin
        if (!legacyOn || (cfgDataAlias && !reqIsCode)) begin
          toDram = 1'b0;
        end else if (granted) begin
          toDram = 1'b1;
        end else begin
          blocked = 1'b1;
        end
      end
      REGION_TOP: begin
        if (!cfgGlobalEn || granted) begin
          toDram    = 1'b1;
          cacheable = 1'b1;
        end else begin
          blocked = 1'b1;
        end
      end
      REGION_MAIN: begin
        toDram    = 1'b1;
        cacheable = 1'b1;
      end
      default: begin
        toDram = 1'b0;
      end
    endcase
    strobe.load      = reqValid;
    strobe.toDram    = toDram;
    strobe.cacheable = cacheable;
    strobe.flagViol  = reqValid && blocked;
    strobe.clearViol = statusClear;
  end

endmodule

// File: rtl/smm_access_decoder.sv
module smm_access_decoder
  import smm_dec_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned SEG_UNIT_SHIFT = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsCode,
  input  logic              smmActive,
  input  logic [ADDR_W-1:0] topOfMem,
  input  logic [2:0]        cfgBaseSeg,
  input  logic              cfgGlobalEn,
  input  logic              cfgDataOpen,
  input  logic              cfgDataAlias,
  input  logic [1:0]        cfgSegSize,
  input  logic              statusClear,
  output logic              rspValid,
  output logic              rspToDram,
  output logic              rspCacheable,
  output logic              violationSticky
);

  region_e   region;
  dpStrobe_t strobe;

  smm_dec_control u_control (
    .region      (region),
    .reqValid    (reqValid),
    .reqIsCode   (reqIsCode),
    .smmActive   (smmActive),
    .cfgBaseSeg  (cfgBaseSeg),
    .cfgGlobalEn (cfgGlobalEn),
    .cfgDataOpen (cfgDataOpen),
    .cfgDataAlias(cfgDataAlias),
    .statusClear (statusClear),
    .strobe      (strobe)
  );

  smm_dec_datapath #(
    .ADDR_W        (ADDR_W),
    .SEG_UNIT_SHIFT(SEG_UNIT_SHIFT)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .reqAddr        (reqAddr),
    .topOfMem       (topOfMem),
    .cfgSegSize     (cfgSegSize),
    .strobe         (strobe),
    .region         (region),
    .rspValid       (rspValid),
    .rspToDram      (rspToDram),
    .rspCacheable   (rspCacheable),
    .violationSticky(violationSticky)
  );

endmodule

// File: rtl/smm_access_decoder_checker.sv
module smm_access_decoder_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqIsCode,
  input logic              smmActive,
  input logic [2:0]        cfgBaseSeg,
  input logic              cfgGlobalEn,
  input logic              cfgDataOpen,
  input logic              cfgDataAlias,
  input logic              statusClear,
  input logic              rspValid,
  input logic              rspToDram,
  input logic              rspCacheable,
  input logic              violationSticky
);

  logic inWindow;
  logic windowOn;
  assign inWindow = (reqAddr >= ADDR_W'(32'h000A_0000)) && (reqAddr <= ADDR_W'(32'h000B_FFFF));
  assign windowOn = cfgGlobalEn && (cfgBaseSeg == 3'b010);

  // R10: response strobe follows request by one cycle
  assert_rsp_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R10: route and attribute hold without a request
  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspToDram) && $stable(rspCacheable)));

  // R2: low window never cacheable
  assert_window_uncached_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inWindow) |=> !rspCacheable);

  // R7: ungranted hidden code fetch to active window is blocked and flagged
  assert_block_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inWindow && windowOn && reqIsCode && !smmActive && !cfgDataOpen)
      |=> (!rspToDram && violationSticky));

  // R8: flag only falls after a clear
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (violationSticky && !statusClear) |=> violationSticky);

  // R3: aliased data access never reaches DRAM
  assert_alias_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inWindow && cfgDataAlias && !reqIsCode) |=> !rspToDram);

  // R11: reset state
  always @(posedge clk) begin
    if (!rstN) begin
      #1;
      assert_reset_state_R11: assert (!rspValid && !rspToDram && !rspCacheable && !violationSticky);
    end
  end

endmodule

bind smm_access_decoder smm_access_decoder_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .reqValid       (reqValid),
  .reqAddr        (reqAddr),
  .reqIsCode      (reqIsCode),
  .smmActive      (smmActive),
  .cfgBaseSeg     (cfgBaseSeg),
  .cfgGlobalEn    (cfgGlobalEn),
  .cfgDataOpen    (cfgDataOpen),
  .cfgDataAlias   (cfgDataAlias),
  .statusClear    (statusClear),
  .rspValid       (rspValid),
  .rspToDram      (rspToDram),
  .rspCacheable   (rspCacheable),
  .violationSticky(violationSticky)
);

// File: tb/smm_access_decoder_bench.sv
module smm_access_decoder_bench;

  localparam int unsigned ADDR_W = 32;
  localparam logic [31:0] TOM    = 32'h0800_0000;
  localparam logic [31:0] WLO    = 32'h000A_0000;
  localparam logic [31:0] WHI    = 32'h000B_FFFF;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic              reqIsCode;
  logic              smmActive;
  logic [ADDR_W-1:0] topOfMem;
  logic [2:0]        cfgBaseSeg;
  logic              cfgGlobalEn;
  logic              cfgDataOpen;
  logic              cfgDataAlias;
  logic [1:0]        cfgSegSize;
  logic              statusClear;
  logic              rspValid;
  logic              rspToDram;
  logic              rspCacheable;
  logic              violationSticky;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smm_access_decoder #(.ADDR_W(ADDR_W)) u_smm_access_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsCode(reqIsCode), .smmActive(smmActive), .topOfMem(topOfMem),
    .cfgBaseSeg(cfgBaseSeg), .cfgGlobalEn(cfgGlobalEn), .cfgDataOpen(cfgDataOpen),
    .cfgDataAlias(cfgDataAlias), .cfgSegSize(cfgSegSize), .statusClear(statusClear),
    .rspValid(rspValid), .rspToDram(rspToDram), .rspCacheable(rspCacheable),
    .violationSticky(violationSticky)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // request issued at negedge, response sampled at the following negedge
  task automatic send(input logic [31:0] addr, input logic code, input logic smm, input logic open);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = addr;
    reqIsCode = code;
    smmActive = smm;
    cfgDataOpen = open;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string req, input logic dram, input logic cach, input logic viol);
    chk({req, " valid"}, 32'(rspValid), 32'd1);
    chk({req, " route"}, 32'(rspToDram), 32'(dram));
    chk({req, " cache"}, 32'(rspCacheable), 32'(cach));
    chk({req, " status"}, 32'(violationSticky), 32'(viol));
  endtask

  task automatic clearFlag();
    @(negedge clk);
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 valid", 32'(rspValid), 0);
    chk("R11 route", 32'(rspToDram), 0);
    chk("R11 cache", 32'(rspCacheable), 0);
    chk("R11 status", 32'(violationSticky), 0);
    rstN = 1'b1;
  endtask

  task automatic t_window_enable();
    cfgGlobalEn = 1'b1; cfgBaseSeg = 3'b011;
    send(WLO, 1'b1, 1'b0, 1'b0);
    expectRsp("R1 wrong base", 1'b0, 1'b0, 1'b0);
    cfgGlobalEn = 1'b0; cfgBaseSeg = 3'b010;
    send(WHI, 1'b1, 1'b1, 1'b0);
    expectRsp("R1 global off", 1'b0, 1'b0, 1'b0);
    cfgGlobalEn = 1'b1;
  endtask

  task automatic t_window_grant();
    send(WLO, 1'b0, 1'b1, 1'b0);
    expectRsp("R2 low end smm", 1'b1, 1'b0, 1'b0);
    send(WHI, 1'b1, 1'b0, 1'b1);
    expectRsp("R2 R6 high end open", 1'b1, 1'b0, 1'b0);
    send(WLO - 1, 1'b0, 1'b0, 1'b0);
    expectRsp("R9 below window", 1'b1, 1'b1, 1'b0);
    send(WHI + 1, 1'b0, 1'b0, 1'b0);
    expectRsp("R9 above window", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_alias();
    cfgDataAlias = 1'b1;
    send(32'h000A_8000, 1'b0, 1'b1, 1'b0);
    expectRsp("R3 alias data smm", 1'b0, 1'b0, 1'b0);
    send(32'h000B_0000, 1'b0, 1'b0, 1'b0);
    expectRsp("R3 alias data ungranted", 1'b0, 1'b0, 1'b0);
    send(32'h000A_8000, 1'b1, 1'b1, 1'b0);
    expectRsp("R3 alias code smm", 1'b1, 1'b0, 1'b0);
    cfgDataAlias = 1'b0;
  endtask

  task automatic t_violation_window();
    send(32'h000A_0100, 1'b1, 1'b0, 1'b0);
    expectRsp("R7 window blocked", 1'b0, 1'b0, 1'b1);
    clearFlag();
    chk("R8 clear alone", 32'(violationSticky), 0);
  endtask

  task automatic t_top_sizes();
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base;
      base = TOM - (32'h0002_0000 << s);
      cfgSegSize = 2'(s);
      send(base, 1'b0, 1'b1, 1'b0);
      expectRsp($sformatf("R4 R5 size%0d base granted", s), 1'b1, 1'b1, 1'b0);
      send(TOM - 1, 1'b1, 1'b0, 1'b1);
      expectRsp($sformatf("R5 R6 size%0d top open", s), 1'b1, 1'b1, 1'b0);
      send(base - 1, 1'b0, 1'b0, 1'b0);
      expectRsp($sformatf("R4 size%0d below base", s), 1'b1, 1'b1, 1'b0);
      send(base, 1'b0, 1'b0, 1'b0);
      expectRsp($sformatf("R4 R7 size%0d base blocked", s), 1'b0, 1'b0, 1'b1);
      clearFlag();
    end
  endtask

  task automatic t_ordinary();
    send(TOM, 1'b0, 1'b0, 1'b0);
    expectRsp("R9 at tom", 1'b0, 1'b0, 1'b0);
    send(32'h0010_0000, 1'b0, 1'b0, 1'b0);
    expectRsp("R9 main dram", 1'b1, 1'b1, 1'b0);
    // R10: no request -> no strobe, outputs hold
    @(negedge clk);
    reqAddr = TOM;
    @(negedge clk);
    chk("R10 idle valid", 32'(rspValid), 0);
    chk("R10 hold route", 32'(rspToDram), 1);
    chk("R10 hold cache", 32'(rspCacheable), 1);
  endtask

  task automatic t_sticky();
    cfgSegSize = 2'b00;
    send(TOM - 32'h10, 1'b0, 1'b0, 1'b0);
    expectRsp("R7 top blocked", 1'b0, 1'b0, 1'b1);
    send(32'h0010_0000, 1'b0, 1'b0, 1'b0);
    expectRsp("R8 persists", 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 persists idle", 32'(violationSticky), 1);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = TOM - 32'h10; smmActive = 1'b0; cfgDataOpen = 1'b0;
    statusClear = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; statusClear = 1'b0;
    chk("R8 clear with new violation", 32'(violationSticky), 1);
    clearFlag();
    chk("R8 cleared", 32'(violationSticky), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reqValid = 0; reqAddr = '0; reqIsCode = 0; smmActive = 0;
    topOfMem = TOM; cfgBaseSeg = 3'b010; cfgGlobalEn = 1; cfgDataOpen = 0;
    cfgDataAlias = 0; cfgSegSize = 2'b00; statusClear = 0; rstN = 0;
    t_reset();
    t_window_enable();
    t_window_grant();
    t_alias();
    t_violation_window();
    t_top_sizes();
    t_ordinary();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule